// File: doc/BRIEF.md
# Saturating Pixel Pack and Expand Unit

A 64-bit SIMD execution unit that converts pixel data between wide fixed-point lanes and narrow byte or halfword lanes. Three pack operations scale each signed lane left by an amount held in a status-register field, then shift it right arithmetically and clamp it to the destination range. Two byte operations need no scale: one widens bytes into 16-bit lanes, and one interleaves the bytes of two 32-bit words.

A caller presents two 64-bit operands, a 3-bit operation code and the status byte together with `in_valid`. The result is registered and appears one clock later, qualified by `out_valid`. Operations that yield 32 bits put them in the low half of `result`.

Top module: `pxfmt_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. While `in_valid` is low, `result` keeps its last value.
- R2: A synchronous active-high `rst` clears `out_valid` and `result` to zero at the next clock edge, even when `in_valid` is high.
- R3: The scale is read from `status` starting at bit 3. The halfword pack (code 0) uses `status[6:3]`, so bit 7 has no effect on it. The two word packs (codes 1 and 2) use `status[7:3]`. Bits 2:0 never matter.
- R4: Code 0, halfword pack. Each signed 16-bit lane i of `src_b` is shifted left by the scale, shifted right arithmetically by 7 and clamped to 0..255. The result goes to `result[8i+7:8i]`.
- R5: Code 1, word pack. The unit starts from `src_a` shifted left by 8 and clears bytes 0 and 4. Each signed 32-bit half h of `src_b` is shifted left by the scale, shifted right arithmetically by 23, clamped to 0..255 and written into byte 4h.
- R6: Code 2, fixed-point pack. Each signed 32-bit half h of `src_b` is shifted left by the scale, shifted right arithmetically by 16 and saturated to -32768..32767. The result goes to `result[16h+15:16h]`.
- R7: Code 3, expand. Byte i of `src_b[31:0]` appears as `result[16i+15:16i] = {4'h0, byte, 4'h0}`.
- R8: Code 4, merge. For byte i, `src_b[8i+7:8i]` goes to `result[16i+7:16i]` and `src_a[8i+7:8i]` goes to `result[16i+15:16i+8]`.
- R9: Codes 5, 6 and 7 produce a zero result. `out_valid` still follows R1.
- R10: The scaled value is kept at full width, so a left shift never wraps. For example, a word lane of 0x7FFFFFFF at scale 31 packs to 255, and 0x80000000 packs to 0.
- R11: Codes 0 and 2 drive `result[63:32]` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and code are valid this cycle |
| op | input | 3 | Operation code (0..4 defined) |
| status | input | 8 | Status byte holding the scale field |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| out_valid | output | 1 | `result` holds a new value |
| result | output | 64 | Registered result |

## Verification
The properties assume that `op`, `src_a` and `src_b` are known values whenever `in_valid` is high. They also assume that reset is applied before the first `in_valid`, so that the lane-placement checks never compare against unreset history. The stimulus starts with several reset cycles and drives every input at the falling edge from a known value, including in the cycles with `in_valid` low. Random cycles mix all eight codes and random status bytes. Directed cycles cover clamping at both ends, the largest scale and reset arriving together with a valid operation.

// File: rtl/pxfmt_pkg.sv
package pxfmt_pkg;
  localparam int DATA_W    = 64;
  localparam int STAT_W    = 8;
  localparam int SCALE_LSB = 3;

  typedef enum logic [2:0] {
    OP_PACK16  = 3'd0,
    OP_PACK32  = 3'd1,
    OP_PACKFIX = 3'd2,
    OP_EXPAND  = 3'd3,
    OP_MERGE   = 3'd4
  } pxfmt_op_e;
endpackage

// File: rtl/pxfmt_sat_lane.sv
// One lane: sign-extend, scale left, arithmetic shift right, clamp.
module pxfmt_sat_lane #(
  parameter int IN_W    = 16,
  parameter int SC_W    = 4,
  parameter int RSH     = 7,
  parameter int OUT_W   = 8,
  parameter bit UNS_OUT = 1'b1
) (
  input  logic [IN_W-1:0]  lane_i,
  input  logic [SC_W-1:0]  scale_i,
  output logic [OUT_W-1:0] lane_o
);
  localparam int WIDE = IN_W + (1 << SC_W);
  localparam logic signed [WIDE-1:0] ONE = WIDE'(1);
  localparam logic signed [WIDE-1:0] HI  = UNS_OUT ? ((ONE <<< OUT_W) - ONE)
                                                   : ((ONE <<< (OUT_W-1)) - ONE);
  localparam logic signed [WIDE-1:0] LO  = UNS_OUT ? {WIDE{1'b0}}
                                                   : -(ONE <<< (OUT_W-1));

  logic signed [WIDE-1:0] ext, shl, shr;

  always_comb begin
    ext = {{(WIDE-IN_W){lane_i[IN_W-1]}}, lane_i};
    shl = ext <<< scale_i;
    shr = shl >>> RSH;
    if (shr < LO)      lane_o = LO[OUT_W-1:0];
    else if (shr > HI) lane_o = HI[OUT_W-1:0];
    else               lane_o = shr[OUT_W-1:0];
  end
endmodule

// File: rtl/pxfmt_bytes.sv
// Expand and merge: pure byte routing.
module pxfmt_bytes #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] expand_o,
  output logic [DATA_W-1:0] merge_o
);
  localparam int NB = DATA_W / 16;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign expand_o[16*g +: 16]  = {4'h0, b_i[8*g +: 8], 4'h0};
    assign merge_o[16*g +: 8]    = b_i[8*g +: 8];
    assign merge_o[16*g+8 +: 8]  = a_i[8*g +: 8];
  end
endmodule

// File: rtl/pxfmt_unit.sv
module pxfmt_unit
  import pxfmt_pkg::*;
#(
  parameter int DW  = pxfmt_pkg::DATA_W,
  parameter int SW  = pxfmt_pkg::STAT_W,
  parameter int SLB = pxfmt_pkg::SCALE_LSB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [2:0]    op,
  input  logic [SW-1:0] status,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  output logic          out_valid,
  output logic [DW-1:0] result
);
  localparam int HW   = DW / 2;
  localparam int N16  = DW / 16;
  localparam int N32  = DW / 32;
  localparam int SC4  = 4;
  localparam int SC5  = 5;

  logic [SC4-1:0] scale4;
  logic [SC5-1:0] scale5;
  assign scale4 = status[SLB +: SC4];
  assign scale5 = status[SLB +: SC5];

  logic [HW-1:0] pk16;
  logic [7:0]    pk32_byte [N32];
  logic [HW-1:0] pkfix;
  logic [DW-1:0] pk32, shifted_a, expand_v, merge_v, next_v;

  for (genvar g = 0; g < N16; g++) begin : g_h16
    pxfmt_sat_lane #(.IN_W(16), .SC_W(SC4), .RSH(7), .OUT_W(8), .UNS_OUT(1'b1)) u_lane (
      .lane_i (src_b[16*g +: 16]),
      .scale_i(scale4),
      .lane_o (pk16[8*g +: 8])
    );
  end

  assign shifted_a = src_a << 8;

  for (genvar g = 0; g < N32; g++) begin : g_w32
    pxfmt_sat_lane #(.IN_W(32), .SC_W(SC5), .RSH(23), .OUT_W(8), .UNS_OUT(1'b1)) u_pk (
      .lane_i (src_b[32*g +: 32]),
      .scale_i(scale5),
      .lane_o (pk32_byte[g])
    );
    pxfmt_sat_lane #(.IN_W(32), .SC_W(SC5), .RSH(16), .OUT_W(16), .UNS_OUT(1'b0)) u_fix (
      .lane_i (src_b[32*g +: 32]),
      .scale_i(scale5),
      .lane_o (pkfix[16*g +: 16])
    );
    assign pk32[32*g +: 32] = {shifted_a[32*g+8 +: 24], pk32_byte[g]};
  end

  pxfmt_bytes #(.DATA_W(DW)) u_bytes (
    .a_i     (src_a),
    .b_i     (src_b),
    .expand_o(expand_v),
    .merge_o (merge_v)
  );

  always_comb begin
    case (pxfmt_op_e'(op))
      OP_PACK16:  next_v = {{HW{1'b0}}, pk16};
      OP_PACK32:  next_v = pk32;
      OP_PACKFIX: next_v = {{HW{1'b0}}, pkfix};
      OP_EXPAND:  next_v = expand_v;
      OP_MERGE:   next_v = merge_v;
      default:    next_v = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_v;
    end
  end
endmodule

// File: rtl/pxfmt_unit_chk.sv
module pxfmt_unit_chk #(
  parameter int DW = 64,
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [2:0]    op,
  input logic [SW-1:0] status,
  input logic [DW-1:0] src_a,
  input logic [DW-1:0] src_b,
  input logic          out_valid,
  input logic [DW-1:0] result
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r1_idle_low: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r1_result_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  a_r2_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));
  a_r11_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == 3'd0 || op == 3'd2)) |=> result[DW-1:DW/2] == '0);
  a_r7_expand_nibbles: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd3) |=> (result & 64'hF00F_F00F_F00F_F00F) == '0);
  a_r5_prev_pixels: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd1) |=> (result[31:8] == $past(src_a[23:0]) &&
                                  result[63:40] == $past(src_a[55:32])));
  a_r8_merge_low: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd4) |=> (result[7:0] == $past(src_b[7:0]) &&
                                  result[15:8] == $past(src_a[7:0])));
  a_r9_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op > 3'd4) |=> result == '0);
endmodule

bind pxfmt_unit pxfmt_unit_chk #(.DW(DW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .status(status),
  .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result)
);

// File: tb/sim_pxfmt_unit.sv
module sim_pxfmt_unit;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [7:0]  status = '0;
  logic [63:0] src_a = '0, src_b = '0;
  logic        out_valid;
  logic [63:0] result;

  int    n_vec = 0, n_bad = 0;
  logic        exp_v = 1'b0;
  logic [63:0] exp_r = '0;
  string       exp_tag = "R2";

  always #(CLK_NS/2) clk = ~clk;

  pxfmt_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .status(status),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result)
  );

  function automatic longint sat(longint t, longint lo, longint hi);
    return (t < lo) ? lo : (t > hi) ? hi : t;
  endfunction

  function automatic logic [63:0] model(int code, logic [7:0] st,
                                        logic [63:0] a, logic [63:0] b);
    int s4 = int'(st[6:3]);
    int s5 = int'(st[7:3]);
    longint t;
    logic [63:0] r = '0;
    case (code)
      0: for (int i = 0; i < 4; i++) begin
           t = longint'($signed(b[16*i +: 16]));
           t = (t <<< s4) >>> 7;
           t = sat(t, 0, 255);
           r[8*i +: 8] = t[7:0];
         end
      1: begin
           r = {a[55:0], 8'h00};
           for (int i = 0; i < 2; i++) begin
             t = longint'($signed(b[32*i +: 32]));
             t = (t <<< s5) >>> 23;
             t = sat(t, 0, 255);
             r[32*i +: 8] = t[7:0];
           end
         end
      2: for (int i = 0; i < 2; i++) begin
           t = longint'($signed(b[32*i +: 32]));
           t = (t <<< s5) >>> 16;
           t = sat(t, -32768, 32767);
           r[16*i +: 16] = t[15:0];
         end
      3: for (int i = 0; i < 4; i++) r[16*i +: 16] = {4'h0, b[8*i +: 8], 4'h0};
      4: for (int i = 0; i < 4; i++) begin
           r[16*i +: 8]   = b[8*i +: 8];
           r[16*i+8 +: 8] = a[8*i +: 8];
         end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check_now();
    n_vec++;
    if (out_valid !== exp_v || result !== exp_r) begin
      n_bad++;
      $display("FAIL %s: valid=%0b result=%h expected valid=%0b result=%h",
               exp_tag, out_valid, result, exp_v, exp_r);
    end
  endtask

  // One cycle: check what the previous cycle produced, then drive the next.
  task automatic step(logic r, logic v, int code, logic [7:0] st,
                      logic [63:0] a, logic [63:0] b, string tag);
    @(negedge clk);
    check_now();
    rst = r; in_valid = v; op = code[2:0]; status = st; src_a = a; src_b = b;
    exp_tag = tag;
    if (r) begin
      exp_v = 1'b0; exp_r = '0;
    end else begin
      exp_v = v;
      if (v) exp_r = model(code, st, a, b);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R2: reset state
    step(1, 0, 0, 8'h00, '0, '0, "R2");
    step(1, 0, 0, 8'h00, '0, '0, "R2");
    step(0, 0, 0, 8'h00, '0, '0, "R2");
    // R4: halfword pack, scale 0, mixed lanes (neg -> 0, big -> 255)
    step(0, 1, 0, 8'h00, '0, 64'h8000_7FFF_0100_3F80, "R4");
    // R3: bit 7 ignored for halfword pack (scale 2 vs 2 with bit 7)
    step(0, 1, 0, 8'h10, '0, 64'h0020_0040_FFFF_0081, "R3");
    step(0, 1, 0, 8'h97, '0, 64'h0020_0040_FFFF_0081, "R3");
    // R3/R11: max scale for halfword pack, upper half zero
    step(0, 1, 0, 8'h78, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0002_0000_FFFF, "R11");
    // R1: idle cycles hold result, valid low
    step(0, 0, 4, 8'h00, 64'h1234, 64'h5678, "R1");
    step(0, 0, 1, 8'hFF, '1, '1, "R1");
    // R5: word pack shifting previous pixels
    step(0, 1, 1, 8'h00, 64'h1122_3344_5566_7788, 64'h7F80_0000_8000_0000, "R5");
    step(0, 1, 1, 8'h38, 64'hA1B2_C3D4_E5F6_0718, 64'h0000_1000_0000_0020, "R5");
    // R10: full-width scaling at scale 31
    step(0, 1, 1, 8'hF8, 64'hCAFE_F00D_DEAD_BEEF, 64'h7FFF_FFFF_8000_0000, "R10");
    step(0, 1, 2, 8'hF8, '0, 64'h7FFF_FFFF_8000_0000, "R10");
    step(0, 1, 1, 8'hF8, '0, 64'h0000_0000_0000_0001, "R10");
    // R6: fixed-point pack, in range and both saturations
    step(0, 1, 2, 8'h00, '0, 64'h0012_3456_FFFE_0000, "R6");
    step(0, 1, 2, 8'h20, '0, 64'h4000_0000_C000_0000, "R6");
    step(0, 1, 2, 8'h08, '1, 64'h0000_8000_FFFF_7FFF, "R6");
    // R7: expand
    step(0, 1, 3, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_80FF_017E, "R7");
    // R8: merge
    step(0, 1, 4, 8'h00, 64'h9999_9999_A1A2_A3A4, 64'h8888_8888_B1B2_B3B4, "R8");
    // R9: unused codes
    step(0, 1, 5, 8'h55, '1, '1, "R9");
    step(0, 1, 6, 8'h55, '1, '1, "R9");
    step(0, 1, 7, 8'h55, '1, '1, "R9");
    // R2: reset while in_valid is high
    step(0, 1, 4, 8'h00, 64'h0102_0304, 64'h0506_0708, "R8");
    step(1, 1, 4, 8'h00, 64'h0102_0304, 64'h0506_0708, "R2");
    step(0, 0, 0, 8'h00, '0, '0, "R2");
    // Random mix
    for (int k = 0; k < 400; k++) begin
      logic [63:0] ra, rb;
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      step(0, ($urandom() % 4) != 0, int'($urandom() % 8), 8'($urandom()),
           ra, rb, "R1");
    end
    step(0, 0, 0, 8'h00, '0, '0, "R1");
    @(negedge clk);
    check_now();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule